// File: doc/BRIEF.md
# Serial Receiver with Per-Character Error Queue

This block deserialises an asynchronous serial line. It samples the line on a 16x oversampling enable and frames each character: a start bit, five to eight data bits sent LSB first, an optional parity bit, and a stop bit. Each completed character goes into a receive queue with its own parity, framing and break markers. The markers are shown to the CPU only while their character is at the head of the queue. A status read clears the markers of the head character. A summary bit reports whether any queued character still carries a marker.

The CPU side has two read strobes. One pops the head character. The other acknowledges the status byte. Two cases are handled on the line itself. After a bad stop bit, the receiver treats that low level as the start of the next character and resynchronises. A line held low for a whole character becomes one zero character carrying the break marker, and reception is re-armed only after the line has been idle for half a bit. The line input must already be synchronous to `clk`. The configuration inputs change only while the receiver is idle and the queue is empty.

Top module: `uart_rx_efifo`

## Requirements
- R1: On `tick16` pulses, a low level seen in idle is confirmed 8 ticks later, and each following bit is sampled 16 ticks after the previous one. `cfg_wlen` 0..3 selects 5..8 data bits, received LSB first, with the unused upper bits of `rdata` reading zero.
- R2: A low level that has gone high again by the confirmation sample is discarded, and no character is queued.
- R3: With `cfg_par_en`=1, one parity bit follows the data: even when `cfg_par_even`=1, odd when it is 0. A mismatch marks that character with the parity marker, shown in `status[2]`.
- R4: A low stop bit marks the character with the framing marker, shown in `status[3]`. That low level is taken as the next start bit, and the first data bit is sampled 16 ticks later.
- R5: A character whose start, data, parity and stop samples are all low is queued once as 0x00. It carries only the break marker, shown in `status[4]`, and nothing more is queued while the line stays low.
- R6: After a break, a new start is accepted only once the line has been high for 8 consecutive ticks. Lows during that wait queue nothing.
- R7: `status[4:2]` shows the markers of the head character, or zero when the queue is empty. A `stat_rd` clears the head's markers but leaves the character in the queue.
- R8: With `cfg_fifo_en`=1, `status[7]` is 1 while any queued character carries a marker. With `cfg_fifo_en`=0 it reads 0.
- R9: Queue capacity is 16 characters with `cfg_fifo_en`=1 and 1 with it 0. A character completing while the queue is full is dropped and sets `status[1]`, which `stat_rd` clears.
- R10: `status[0]` is 1 while the queue holds a character, and `rdata` shows the head character (0 when the queue is empty). `data_rd` removes the head character. `status[6:5]` read 0.
- R11: `lsi_irq` is 1 when `cfg_lsi_en`=1 and any of `status[4:1]` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Oversampling enable, 16 per bit time |
| rxd | input | 1 | Serial line, idle high, already synchronous |
| cfg_wlen | input | 2 | Data bits minus five |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd |
| cfg_fifo_en | input | 1 | 1 = 16-deep queue, 0 = single holding slot |
| cfg_lsi_en | input | 1 | Line status interrupt enable |
| data_rd | input | 1 | Pop the head character |
| rdata | output | 8 | Head character |
| stat_rd | input | 1 | Status read acknowledge |
| status | output | 8 | {any marker, 0, 0, break, framing, parity, overrun, ready} |
| lsi_irq | output | 1 | Line status interrupt request |

## Verification
If the bit counter or the sampling phase is wrong, the queued character will not match the expected one. This appears at `rdata` the cycle after the stop sample, so the bench compares against a reference queue on every clock. A marker stored in the wrong entry, or one that was not cleared, shows in `status[4:2]` only once that entry reaches the head. A bad queue-wide summary shows at once in `status[7]`. A break or resync state machine that fails to re-arm shows as a missing or extra queued character some ticks after the line returns high.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int OVS      = 16;
  localparam int OVS_W    = $clog2(OVS);
  localparam logic [OVS_W-1:0] MID_CNT  = OVS_W'(OVS / 2 - 1);
  localparam logic [OVS_W-1:0] LAST_CNT = OVS_W'(OVS - 1);
  localparam int DATA_W   = 8;
  localparam int FLAG_W   = 3;   // [0] parity, [1] framing, [2] break

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP,
    RX_BRKW
  } rx_state_t;
endpackage

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
  import uart_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic [1:0]        wlen,
  input  logic              par_en,
  input  logic              par_even,
  output logic              push,
  output logic [DATA_W-1:0] push_data,
  output logic [FLAG_W-1:0] push_flags
);
  rx_state_t         st_q, st_n;
  logic [OVS_W-1:0]  cnt_q, cnt_n;
  logic [2:0]        bidx_q, bidx_n;
  logic [DATA_W-1:0] sh_q, sh_n;
  logic              acc_q, acc_n;
  logic              low_q, low_n;
  logic              perr_q, perr_n;
  logic              last_bit;

  assign last_bit = (bidx_q == (3'(wlen) + 3'd4));

  always_comb begin
    st_n       = st_q;
    cnt_n      = cnt_q;
    bidx_n     = bidx_q;
    sh_n       = sh_q;
    acc_n      = acc_q;
    low_n      = low_q;
    perr_n     = perr_q;
    push       = 1'b0;
    push_data  = sh_q;
    push_flags = '0;
    if (tick) begin
      unique case (st_q)
        RX_IDLE: begin
          if (!rxd) begin
            st_n  = RX_START;
            cnt_n = '0;
          end
        end
        RX_START: begin
          if (cnt_q == MID_CNT) begin
            if (rxd) begin
              st_n = RX_IDLE;
            end else begin
              st_n   = RX_DATA;
              cnt_n  = '0;
              bidx_n = '0;
              sh_n   = '0;
              acc_n  = 1'b0;
              low_n  = 1'b1;
              perr_n = 1'b0;
            end
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt_q == LAST_CNT) begin
            cnt_n        = '0;
            sh_n[bidx_q] = rxd;
            acc_n        = acc_q ^ rxd;
            low_n        = low_q & ~rxd;
            if (last_bit) st_n = par_en ? RX_PAR : RX_STOP;
            else          bidx_n = bidx_q + 1'b1;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        RX_PAR: begin
          if (cnt_q == LAST_CNT) begin
            cnt_n  = '0;
            perr_n = acc_q ^ rxd ^ ~par_even;
            low_n  = low_q & ~rxd;
            st_n   = RX_STOP;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (cnt_q == LAST_CNT) begin
            push  = 1'b1;
            cnt_n = '0;
            if (rxd) begin
              push_flags = {2'b00, perr_q};
              st_n       = RX_IDLE;
            end else if (low_q) begin
              push_data  = '0;
              push_flags = 3'b100;
              st_n       = RX_BRKW;
            end else begin
              // bad stop level becomes the next start bit
              push_flags = {1'b0, 1'b1, perr_q};
              st_n       = RX_DATA;
              bidx_n     = '0;
              sh_n       = '0;
              acc_n      = 1'b0;
              low_n      = 1'b1;
              perr_n     = 1'b0;
            end
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        RX_BRKW: begin
          if (rxd) begin
            if (cnt_q == MID_CNT) st_n = RX_IDLE;
            else                  cnt_n = cnt_q + 1'b1;
          end else begin
            cnt_n = '0;
          end
        end
        default: st_n = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      bidx_q <= '0;
      sh_q   <= '0;
      acc_q  <= 1'b0;
      low_q  <= 1'b0;
      perr_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      bidx_q <= bidx_n;
      sh_q   <= sh_n;
      acc_q  <= acc_n;
      low_q  <= low_n;
      perr_q <= perr_n;
    end
  end
endmodule

// File: rtl/uart_rx_errfifo.sv
module uart_rx_errfifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic [FLAG_W-1:0] push_flags,
  input  logic              pop_req,
  input  logic              clr_head,
  output logic [DATA_W-1:0] head_data,
  output logic [FLAG_W-1:0] head_flags,
  output logic [CW-1:0]     cnt,
  output logic              any_err,
  output logic              full
);
  localparam logic [CW-1:0] CAP_DEEP = CW'(DEPTH);

  logic [AW-1:0]     wptr_q, wptr_n, rptr_q, rptr_n;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic              nonempty, wr, rd, clr;
  logic [DATA_W-1:0] d_arr [DEPTH];
  logic [FLAG_W-1:0] f_arr [DEPTH];
  logic [DEPTH-1:0]  err_vec;

  assign nonempty = (cnt_q != '0);
  assign full     = (cnt_q >= (fifo_en ? CAP_DEEP : CW'(1)));
  assign wr       = push & ~full;
  assign rd       = pop_req & nonempty;
  assign clr      = clr_head & nonempty;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [DATA_W-1:0] d_q;
    logic [FLAG_W-1:0] f_q;
    logic              hit_w, hit_c, valid;
    logic [AW-1:0]     off;

    assign hit_w = wr  && (wptr_q == AW'(i));
    assign hit_c = clr && (rptr_q == AW'(i));
    assign off   = AW'(i) - rptr_q;
    assign valid = (CW'(off) < cnt_q);

    always_ff @(posedge clk) begin
      if (hit_w) d_q <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     f_q <= '0;
      else if (hit_w) f_q <= push_flags;
      else if (hit_c) f_q <= '0;
    end

    assign d_arr[i]   = d_q;
    assign f_arr[i]   = f_q;
    assign err_vec[i] = valid & (|f_q);
  end

  always_comb begin
    wptr_n = wptr_q + (wr ? AW'(1) : AW'(0));
    rptr_n = rptr_q + (rd ? AW'(1) : AW'(0));
    cnt_n  = cnt_q;
    if (wr && !rd)      cnt_n = cnt_q + 1'b1;
    else if (rd && !wr) cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_n;
      rptr_q <= rptr_n;
      cnt_q  <= cnt_n;
    end
  end

  assign head_data  = nonempty ? d_arr[rptr_q] : '0;
  assign head_flags = nonempty ? f_arr[rptr_q] : '0;
  assign cnt        = cnt_q;
  assign any_err    = |err_vec;
endmodule

// File: rtl/uart_rx_efifo.sv
module uart_rx_efifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rxd,
  input  logic [1:0] cfg_wlen,
  input  logic       cfg_par_en,
  input  logic       cfg_par_even,
  input  logic       cfg_fifo_en,
  input  logic       cfg_lsi_en,
  input  logic       data_rd,
  output logic [7:0] rdata,
  input  logic       stat_rd,
  output logic [7:0] status,
  output logic       lsi_irq
);
  logic              push_vld;
  logic [DATA_W-1:0] push_data;
  logic [FLAG_W-1:0] push_flags;
  logic [FLAG_W-1:0] head_flags;
  logic [CW-1:0]     fifo_cnt;
  logic              any_err, fifo_full;
  logic              ovr_q, ovr_n;

  uart_rx_framer u_framer (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick16),
    .rxd        (rxd),
    .wlen       (cfg_wlen),
    .par_en     (cfg_par_en),
    .par_even   (cfg_par_even),
    .push       (push_vld),
    .push_data  (push_data),
    .push_flags (push_flags)
  );

  uart_rx_errfifo #(.DEPTH(DEPTH)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_en    (cfg_fifo_en),
    .push       (push_vld),
    .push_data  (push_data),
    .push_flags (push_flags),
    .pop_req    (data_rd),
    .clr_head   (stat_rd),
    .head_data  (rdata),
    .head_flags (head_flags),
    .cnt        (fifo_cnt),
    .any_err    (any_err),
    .full       (fifo_full)
  );

  always_comb begin
    ovr_n = ovr_q;
    if (push_vld && fifo_full) ovr_n = 1'b1;
    else if (stat_rd)          ovr_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_q <= 1'b0;
    else        ovr_q <= ovr_n;
  end

  assign status  = {cfg_fifo_en & any_err, 2'b00, head_flags, ovr_q, (fifo_cnt != '0)};
  assign lsi_irq = cfg_lsi_en & (|status[4:1]);
endmodule

// File: rtl/uart_rx_efifo_chk.sv
module uart_rx_efifo_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_fifo_en,
  input logic          data_rd,
  input logic          stat_rd,
  input logic [7:0]    status,
  input logic          push_vld,
  input logic [2:0]    push_flags,
  input logic [CW-1:0] fifo_cnt
);
  logic full;
  assign full = fifo_cnt >= (cfg_fifo_en ? CW'(DEPTH) : CW'(1));

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CW'(DEPTH));

  // R9
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_vld && full) |=> status[1]);

  // R9
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1] && !stat_rd) |=> status[1]);

  // R7
  head_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !data_rd && status[0]) |=> (status[4:2] == 3'b000));

  // R5
  brk_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_vld && push_flags[2] && !full) |=> status[0]);

  // R10
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && fifo_cnt == CW'(1) && !push_vld) |=> !status[0]);
endmodule

bind uart_rx_efifo uart_rx_efifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_fifo_en (cfg_fifo_en),
  .data_rd     (data_rd),
  .stat_rd     (stat_rd),
  .status      (status),
  .push_vld    (push_vld),
  .push_flags  (push_flags),
  .fifo_cnt    (fifo_cnt)
);

// File: tb/uart_rx_efifo_tb.sv
`timescale 1ns/1ps
module uart_rx_efifo_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick16, rxd, cfg_par_en, cfg_par_even, cfg_fifo_en, cfg_lsi_en;
  logic [1:0] cfg_wlen;
  logic       data_rd, stat_rd, lsi_irq;
  logic [7:0] rdata, status;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  logic [10:0] mq[$];       // {break, framing, parity, data}
  logic        m_ovr;
  logic        line_q[$];
  int          sch_t[$];
  logic [10:0] sch_e[$];

  always #10 clk = ~clk;

  uart_rx_efifo u_dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
    .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
    .cfg_fifo_en(cfg_fifo_en), .cfg_lsi_en(cfg_lsi_en),
    .data_rd(data_rd), .rdata(rdata), .stat_rd(stat_rd),
    .status(status), .lsi_irq(lsi_irq)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_edge(bit push, logic [10:0] e);
    int cap  = cfg_fifo_en ? 16 : 1;
    bit full = (mq.size() >= cap);
    if (stat_rd) begin
      if (mq.size() != 0) mq[0][10:8] = 3'b000;
      m_ovr = 1'b0;
    end
    if (data_rd && mq.size() != 0) void'(mq.pop_front());
    if (push) begin
      if (full) m_ovr = 1'b1;
      else      mq.push_back(e);
    end
  endtask

  task automatic compare();
    logic [7:0] ed = (mq.size() != 0) ? mq[0][7:0] : 8'h00;
    logic [2:0] ef = (mq.size() != 0) ? mq[0][10:8] : 3'b000;
    bit any = 1'b0;
    bit eirq;
    foreach (mq[i]) if (mq[i][10:8] != 3'b000) any = 1'b1;
    eirq = cfg_lsi_en && (m_ovr || ef != 3'b000);
    chk(status[0] == (mq.size() != 0), "R10 ready", int'(status[0]), int'(mq.size() != 0));
    chk(rdata == ed, "R10 rdata", int'(rdata), int'(ed));
    chk(status[6:5] == 2'b00, "R10 spare", int'(status[6:5]), 0);
    chk(status[1] == m_ovr, "R9 overrun", int'(status[1]), int'(m_ovr));
    chk(status[4:2] == ef, "R7 head flags", int'(status[4:2]), int'(ef));
    chk(status[7] == (cfg_fifo_en && any), "R8 any marker", int'(status[7]), int'(cfg_fifo_en && any));
    chk(lsi_irq == eirq, "R11 irq", int'(lsi_irq), int'(eirq));
  endtask

  task automatic step(bit tk, logic r, bit rd, bit sr, bit push, logic [10:0] e);
    tick16 = tk; rxd = r; data_rd = rd; stat_rd = sr;
    @(posedge clk);
    model_edge(push, e);
    @(negedge clk);
    compare();
  endtask

  task automatic add_ticks(logic v, int n);
    for (int i = 0; i < n; i++) line_q.push_back(v);
  endtask

  task automatic add_bit(logic v);
    add_ticks(v, 16);
  endtask

  task automatic add_frame(logic [7:0] d, bit bad_par, logic stop_v, bit with_start);
    int nb = int'(cfg_wlen) + 5;
    logic [7:0] dm = d & ((8'h01 << nb) - 8'h01);
    logic p;
    if (with_start) add_bit(1'b0);
    for (int i = 0; i < nb; i++) add_bit(dm[i]);
    if (cfg_par_en) begin
      p = (^dm) ^ ~cfg_par_even;
      add_bit(p ^ bad_par);
    end
    sch_t.push_back(line_q.size() + 8);
    sch_e.push_back({1'b0, ~stop_v, bad_par & cfg_par_en, dm});
    add_bit(stop_v);
  endtask

  task automatic run_line();
    for (int k = 0; k < line_q.size(); k++) begin
      bit p = 1'b0;
      logic [10:0] e = '0;
      if (sch_t.size() != 0 && sch_t[0] == k) begin
        p = 1'b1;
        e = sch_e.pop_front();
        void'(sch_t.pop_front());
      end
      step(1'b1, line_q[k], 1'b0, 1'b0, p, e);
    end
    line_q.delete();
  endtask

  task automatic expect_pop(logic [7:0] d, logic [2:0] f, string tag);
    chk(rdata == d, tag, int'(rdata), int'(d));
    chk(status[4:2] == f, tag, int'(status[4:2]), int'(f));
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, '0);
  endtask

  task automatic read_stat();
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, '0);
  endtask

  task automatic set_cfg(logic [1:0] wl, logic pe, logic ev);
    cfg_wlen = wl; cfg_par_en = pe; cfg_par_even = ev;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R10 watchdog actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick16 = 1'b0; rxd = 1'b1; data_rd = 1'b0; stat_rd = 1'b0;
    cfg_fifo_en = 1'b1; cfg_lsi_en = 1'b1; set_cfg(2'd3, 1'b0, 1'b0);
    m_ovr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 R11 reset state
    chk(status == 8'h00, "R10 reset status", int'(status), 0);
    chk(lsi_irq == 1'b0, "R11 reset irq", int'(lsi_irq), 0);

    // R1: 8N1 characters, LSB first
    add_bit(1); add_bit(1);
    add_frame(8'hA5, 0, 1, 1); add_bit(1);
    add_frame(8'h3C, 0, 1, 1); add_bit(1); add_bit(1);
    run_line();
    expect_pop(8'hA5, 3'b000, "R1 first char");
    expect_pop(8'h3C, 3'b000, "R10 second char");
    chk(status[0] == 1'b0, "R10 empty after pops", int'(status[0]), 0);

    // R3: 7 bits even parity, one mismatch
    set_cfg(2'd2, 1'b1, 1'b1);
    add_bit(1); add_frame(8'h55, 0, 1, 1); add_bit(1);
    add_frame(8'h2A, 1, 1, 1); add_bit(1); add_bit(1);
    run_line();
    chk(status[7] == 1'b1, "R8 marker behind head", int'(status[7]), 1);
    expect_pop(8'h55, 3'b000, "R3 good parity");
    chk(status[4:2] == 3'b001, "R3 parity marker", int'(status[4:2]), 1);
    chk(lsi_irq == 1'b1, "R11 irq on parity", int'(lsi_irq), 1);
    read_stat();
    chk(status[4:2] == 3'b000, "R7 cleared by status read", int'(status[4:2]), 0);
    chk(rdata == 8'h2A, "R7 char kept after status read", int'(rdata), 8'h2A);
    expect_pop(8'h2A, 3'b000, "R3 bad parity char");

    // R1 R3: 5 bits odd parity
    set_cfg(2'd0, 1'b1, 1'b0);
    add_bit(1); add_frame(8'h13, 0, 1, 1); add_bit(1);
    add_frame(8'hFF, 0, 1, 1); add_bit(1);
    run_line();
    expect_pop(8'h13, 3'b000, "R1 five bits");
    expect_pop(8'h1F, 3'b000, "R3 odd parity, upper bits zero");

    // R2: short low is a glitch
    set_cfg(2'd3, 1'b0, 1'b0);
    add_bit(1); add_ticks(0, 5); add_ticks(1, 11); add_bit(1); add_bit(1);
    run_line();
    chk(status[0] == 1'b0, "R2 glitch ignored", int'(status[0]), 0);
    add_frame(8'h7E, 0, 1, 1); add_bit(1);
    run_line();
    expect_pop(8'h7E, 3'b000, "R2 receiver alive after glitch");

    // R4: framing error and resync on the bad stop bit
    add_bit(1); add_bit(1);
    add_frame(8'h81, 0, 0, 1);
    add_frame(8'h5A, 0, 1, 0);
    add_bit(1); add_bit(1);
    run_line();
    expect_pop(8'h81, 3'b010, "R4 framing marker");
    expect_pop(8'h5A, 3'b000, "R4 resync char");

    // R5 R6: break, short high, long low, then idle half bit
    begin
      int t0;
      add_bit(1); add_bit(1);
      t0 = line_q.size();
      add_ticks(0, 260);
      sch_t.push_back(t0 + 152);
      sch_e.push_back(11'b100_0000_0000);
      add_ticks(1, 4); add_ticks(0, 40); add_ticks(1, 20);
      add_frame(8'h42, 0, 1, 1); add_bit(1);
      run_line();
    end
    expect_pop(8'h00, 3'b100, "R5 single break char");
    expect_pop(8'h42, 3'b000, "R6 restart after idle");
    chk(status[0] == 1'b0, "R5 no extra chars", int'(status[0]), 0);

    // R7 R8: marker in the middle of the queue
    set_cfg(2'd3, 1'b1, 1'b1);
    add_bit(1); add_frame(8'h11, 0, 1, 1); add_bit(1);
    add_frame(8'h22, 1, 1, 1); add_bit(1);
    add_frame(8'h33, 0, 1, 1); add_bit(1);
    run_line();
    chk(status[7] == 1'b1, "R8 summary set", int'(status[7]), 1);
    chk(status[4:2] == 3'b000, "R7 head clean", int'(status[4:2]), 0);
    read_stat();
    chk(status[7] == 1'b1, "R8 summary survives read", int'(status[7]), 1);
    expect_pop(8'h11, 3'b000, "R7 head one");
    chk(status[4:2] == 3'b001, "R7 marker at head", int'(status[4:2]), 1);
    read_stat();
    chk(status[7] == 1'b0, "R8 summary cleared", int'(status[7]), 0);
    expect_pop(8'h22, 3'b000, "R7 head two");
    expect_pop(8'h33, 3'b000, "R7 head three");

    // R9: overrun in 16-deep mode
    set_cfg(2'd3, 1'b0, 1'b0);
    add_bit(1);
    for (int i = 0; i < 17; i++) begin
      add_frame(8'h40 + 8'(i), 0, 1, 1); add_bit(1);
    end
    run_line();
    chk(status[1] == 1'b1, "R9 overrun set", int'(status[1]), 1);
    chk(lsi_irq == 1'b1, "R11 irq on overrun", int'(lsi_irq), 1);
    read_stat();
    chk(status[1] == 1'b0, "R9 overrun cleared", int'(status[1]), 0);
    for (int i = 0; i < 16; i++) expect_pop(8'h40 + 8'(i), 3'b000, "R9 kept chars");
    chk(status[0] == 1'b0, "R9 extra char dropped", int'(status[0]), 0);

    // R8 R9: single-slot mode
    cfg_fifo_en = 1'b0;
    set_cfg(2'd2, 1'b1, 1'b1);
    add_bit(1); add_frame(8'h2A, 1, 1, 1); add_bit(1);
    add_frame(8'h15, 0, 1, 1); add_bit(1);
    run_line();
    chk(status[7] == 1'b0, "R8 summary off in single mode", int'(status[7]), 0);
    chk(status[1] == 1'b1, "R9 single slot overrun", int'(status[1]), 1);
    expect_pop(8'h2A, 3'b001, "R9 first char kept");
    chk(status[0] == 1'b0, "R9 second dropped", int'(status[0]), 0);
    read_stat();

    // R11: interrupt disabled
    cfg_fifo_en = 1'b1;
    cfg_lsi_en  = 1'b0;
    add_bit(1); add_frame(8'h2A, 1, 1, 1); add_bit(1);
    run_line();
    chk(lsi_irq == 1'b0, "R11 masked", int'(lsi_irq), 0);
    chk(status[2] == 1'b1, "R11 marker still shown", int'(status[2]), 1);
    read_stat();
    expect_pop(8'h2A, 3'b000, "R11 drain");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule